// File: doc/BRIEF.md
# Signed Quadword to Decimal Text Converter

This unit turns a signed 64-bit integer into a run of decimal ASCII characters and writes them, one byte at a time, into a caller-chosen memory field. The caller names the field by its lowest byte address and its length in bytes, pulses `start`, and waits for `done`. The magnitude of the operand is what gets printed. No minus sign is written. The sign and zero-ness of the original operand are reported on a three-wire condition code.

The text is right-justified in the field. The least significant digit lands in the last byte of the field, and any leading positions that the number does not need are padded with the character '0'. The digits come from repeated division by ten, one bit of quotient per clock, least significant digit first. When the field is shorter than the number of significant digits, the high-order digits are lost and `overflow` is raised.

Memory writes use a valid/ready handshake, so the unit can sit in front of a shared store that sometimes stalls.

Top module: `quad_ascii_conv`

## Requirements
- R1: A `start` pulse seen while `busy` is low latches the operand, the start address and the byte count, and `busy` is high on the following cycle. A `start` seen while `busy` is high is ignored and does not change the result.
- R2: Each written byte is 0x30 plus one decimal digit (0x30..0x39). Exactly `byteCount` bytes are written, at addresses start+count-1 down to start in that order. The least significant digit goes first, and positions above the most significant digit hold 0x30.
- R3: For a negative operand the digits are those of its absolute value, including the most negative 64-bit value, which prints as 9223372036854775808.
- R4: At `done`, `overflow` is 1 exactly when the magnitude is at least 10 to the power `byteCount`, that is, when significant digits were dropped.
- R5: With a byte count of zero no byte is written, and `overflow` is 1 exactly when the operand is nonzero.
- R6: At `done`, exactly one of `ccLess`, `ccEqual`, `ccGreater` is high: less for a negative operand, equal for zero, greater for positive. The condition code and `overflow` hold their values until the next accepted start.
- R7: A byte is transferred on a clock edge where `wrValid` and `wrReady` are both high. While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr` and `wrData` stay unchanged.
- R8: `done` is a one-cycle pulse after the last accepted write (or after the start, for a zero count), and `busy` is low on the cycle after `done`.
- R9: After reset, `busy`, `done`, `wrValid`, `overflow` and all three condition code outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken only when idle) |
| operand | input | 64 | Signed value to convert |
| startAddr | input | 16 | Lowest byte address of the destination field |
| byteCount | input | 8 | Length of the destination field in bytes |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| ccLess | output | 1 | Operand was negative |
| ccEqual | output | 1 | Operand was zero |
| ccGreater | output | 1 | Operand was positive |
| overflow | output | 1 | Significant digits were cut off |
| wrValid | output | 1 | Write request to memory |
| wrReady | input | 1 | Memory accepts the write this cycle |
| wrAddr | output | 16 | Byte address of the write |
| wrData | output | 8 | ASCII digit to write |

## Verification
Directed operands cover zero, single digits on both sides of ten, a negative value whose field is too short, the largest positive value, and the most negative value in a field that fits it exactly and in one that is a byte short. Together these separate the sign, magnitude and overflow paths. A zero-length field is tried with both a zero and a nonzero operand, which tests whether overflow depends on the operand alone. Random full-width and small operands with random field lengths and a randomly stalling write port check digit order, padding and address sequencing against a reference computed with ordinary modulo arithmetic. One run receives a second `start` in mid-conversion to show that it is ignored.

// File: rtl/qa_pkg.sv
package qa_pkg;
  typedef struct packed {
    logic load;     // latch operand and field, reset divider
    logic divStep;  // one shift-subtract step
    logic commit;   // digit accepted: advance address, reload divider
    logic finish;   // capture overflow
  } qa_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DIV,
    ST_WRITE,
    ST_DONE
  } qa_state_t;
endpackage

// File: rtl/qa_datapath.sv
module qa_datapath
  import qa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  qa_strobe_t        strobe,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              cntZero,
  output logic              cntLast,
  output logic              bitLast,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              ccLess,
  output logic              ccEqual,
  output logic              ccGreater,
  output logic              overflow
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [4:0] TEN = 5'd10;

  logic [DATA_W-1:0] divWork;
  logic [3:0]        divRem;
  logic [BIT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remaining;

  logic [DATA_W-1:0] magnitude;
  logic [4:0]        partial;
  logic              geTen;

  assign magnitude = operand[DATA_W-1] ? (~operand + 1'b1) : operand;
  assign partial   = {divRem, divWork[DATA_W-1]};
  assign geTen     = (partial >= TEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divWork   <= '0;
      divRem    <= '0;
      bitCnt    <= '0;
      curAddr   <= '0;
      remaining <= '0;
      ccLess    <= 1'b0;
      ccEqual   <= 1'b0;
      ccGreater <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (strobe.load) begin
        divWork   <= magnitude;
        divRem    <= '0;
        bitCnt    <= '0;
        curAddr   <= startAddr + ADDR_W'(byteCount) - 1'b1;
        remaining <= byteCount;
        ccLess    <= operand[DATA_W-1];
        ccEqual   <= (operand == '0);
        ccGreater <= !operand[DATA_W-1] && (operand != '0);
        overflow  <= 1'b0;
      end
      if (strobe.divStep) begin
        divRem  <= geTen ? 4'(partial - TEN) : partial[3:0];
        divWork <= {divWork[DATA_W-2:0], geTen};
        bitCnt  <= bitCnt + 1'b1;
      end
      if (strobe.commit) begin
        divRem    <= '0;
        bitCnt    <= '0;
        curAddr   <= curAddr - 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (strobe.finish) begin
        overflow <= (divWork != '0);
      end
    end
  end

  assign cntZero = (remaining == '0);
  assign cntLast = (remaining == CNT_W'(1));
  assign bitLast = (bitCnt == LAST_BIT);
  assign wrAddr  = curAddr;
  assign wrData  = {4'h3, divRem};
endmodule

// File: rtl/qa_control.sv
module qa_control
  import qa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrReady,
  input  logic       cntZero,
  input  logic       cntLast,
  input  logic       bitLast,
  output qa_strobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       wrValid
);
  qa_state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cntZero) begin
          strobe.finish = 1'b1;
          stateNext     = ST_DONE;
        end else begin
          stateNext = ST_DIV;
        end
      end
      ST_DIV: begin
        strobe.divStep = 1'b1;
        if (bitLast) stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        if (wrReady) begin
          strobe.commit = 1'b1;
          if (cntLast) begin
            strobe.finish = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            stateNext = ST_DIV;
          end
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign wrValid = (state == ST_WRITE);
endmodule

// File: rtl/quad_ascii_conv.sv
module quad_ascii_conv
  import qa_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  output logic              busy,
  output logic              done,
  output logic              ccLess,
  output logic              ccEqual,
  output logic              ccGreater,
  output logic              overflow,
  output logic              wrValid,
  input  logic              wrReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);
  qa_strobe_t strobe;
  logic cntZero, cntLast, bitLast;

  qa_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wrReady(wrReady),
    .cntZero(cntZero), .cntLast(cntLast), .bitLast(bitLast),
    .strobe(strobe), .busy(busy), .done(done), .wrValid(wrValid)
  );

  qa_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .operand(operand),
    .startAddr(startAddr), .byteCount(byteCount),
    .cntZero(cntZero), .cntLast(cntLast), .bitLast(bitLast),
    .wrAddr(wrAddr), .wrData(wrData),
    .ccLess(ccLess), .ccEqual(ccEqual), .ccGreater(ccGreater),
    .overflow(overflow)
  );
endmodule

// File: rtl/quad_ascii_conv_chk.sv
module quad_ascii_conv_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              ccLess,
  input logic              ccEqual,
  input logic              ccGreater,
  input logic              overflow,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData
);
  // R1
  start_taken_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrData >= 8'h30 && wrData <= 8'h39));

  // R6
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({ccLess, ccEqual, ccGreater}) == 1));

  // R6
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable({ccLess, ccEqual, ccGreater})));

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!busy && !done));

  // R8
  write_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (busy && !done));
endmodule

bind quad_ascii_conv quad_ascii_conv_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .ccLess(ccLess), .ccEqual(ccEqual), .ccGreater(ccGreater),
  .overflow(overflow), .wrValid(wrValid), .wrReady(wrReady),
  .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/quad_ascii_conv_tb.sv
module quad_ascii_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LOG    = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] operand = '0;
  logic [15:0] startAddr = '0;
  logic [7:0]  byteCount = '0;
  logic        busy, done, ccLess, ccEqual, ccGreater, overflow;
  logic        wrValid;
  logic        wrReady = 1'b0;
  logic [15:0] wrAddr;
  logic [7:0]  wrData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit readyRandom = 1'b0;

  logic [15:0] logAddr [MAX_LOG];
  logic [7:0]  logData [MAX_LOG];
  int logCount = 0;
  int holdViolations = 0;
  logic        prevStall = 1'b0;
  logic [15:0] prevAddr = '0;
  logic [7:0]  prevData = '0;

  quad_ascii_conv u_dut (
    .clk(clk), .rstN(rstN), .start(start), .operand(operand),
    .startAddr(startAddr), .byteCount(byteCount), .busy(busy), .done(done),
    .ccLess(ccLess), .ccEqual(ccEqual), .ccGreater(ccGreater),
    .overflow(overflow), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (readyRandom) wrReady <= ($urandom % 4) != 0;
    else             wrReady <= 1'b1;
  end

  // R7: log accepted writes and watch stall hold behaviour
  always @(posedge clk) begin
    if (rstN) begin
      if (prevStall && !(wrValid && wrAddr == prevAddr && wrData == prevData))
        holdViolations++;
      prevStall <= wrValid && !wrReady;
      prevAddr  <= wrAddr;
      prevData  <= wrData;
      if (wrValid && wrReady) begin
        if (logCount < MAX_LOG) begin
          logAddr[logCount] = wrAddr;
          logData[logCount] = wrData;
        end
        logCount++;
      end
    end
  end

  task automatic report(input string req, input bit ok, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] absVal(input logic [63:0] v);
    return v[63] ? (~v + 64'd1) : v;
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      finishRun();
    end
  end

  task automatic runOp(input logic [63:0] val, input logic [15:0] addr,
                       input logic [7:0] cnt, input bit interfere);
    logic [63:0] rest;
    logic [7:0]  expData;
    logic [15:0] expAddr;
    bit          digitsOk;
    int          badIdx;
    int          waitCycles;
    logic [2:0]  expCc;
    @(negedge clk);
    logCount  = 0;
    operand   = val;
    startAddr = addr;
    byteCount = cnt;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    report("R1", busy === 1'b1, "busy after start", 128'(busy), 128'(1));
    if (interfere) begin
      repeat (20) @(negedge clk);
      operand   = ~val;
      byteCount = cnt + 8'd3;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      operand   = val;
      byteCount = cnt;
    end
    waitCycles = 0;
    while (done !== 1'b1 && waitCycles < 20000) begin
      @(negedge clk);
      waitCycles++;
    end
    report("R8", done === 1'b1, "done pulse", 128'(done), 128'(1));
    // expected text from plain modulo arithmetic
    rest     = absVal(val);
    digitsOk = (logCount == int'(cnt));
    badIdx   = -1;
    for (int i = 0; i < int'(cnt); i++) begin
      expData = 8'h30 + 8'(rest % 64'd10);
      expAddr = addr + 16'(cnt) - 16'd1 - 16'(i);
      rest    = rest / 64'd10;
      if (i < logCount && i < MAX_LOG && digitsOk)
        if (logAddr[i] !== expAddr || logData[i] !== expData) begin
          digitsOk = 1'b0;
          badIdx   = i;
        end
    end
    if (cnt == 8'd0)
      report("R5", logCount == 0, "writes for empty field", 128'(logCount), 128'(0));
    else if (badIdx >= 0)
      report(val[63] ? "R3" : "R2", 1'b0, "digit byte",
             {logAddr[badIdx], logData[badIdx]}, 128'(badIdx));
    else
      report(val[63] ? "R3" : "R2", digitsOk, "write count",
             128'(logCount), 128'(cnt));
    report(cnt == 8'd0 ? "R5" : "R4", overflow === (rest != 64'd0), "overflow",
           128'(overflow), 128'(rest != 64'd0));
    expCc = val[63] ? 3'b100 : (val == 64'd0 ? 3'b010 : 3'b001);
    report("R6", {ccLess, ccEqual, ccGreater} === expCc, "condition code",
           128'({ccLess, ccEqual, ccGreater}), 128'(expCc));
    @(negedge clk);
    report("R8", busy === 1'b0 && done === 1'b0, "idle after done",
           128'({busy, done}), 128'(0));
    if (interfere)
      report("R1", overflow === (rest != 64'd0), "start while busy ignored",
             128'(overflow), 128'(rest != 64'd0));
    repeat (2) @(negedge clk);
    report("R6", {ccLess, ccEqual, ccGreater} === expCc, "condition code held",
           128'({ccLess, ccEqual, ccGreater}), 128'(expCc));
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R9: reset state
    report("R9", {busy, done, wrValid, overflow, ccLess, ccEqual, ccGreater} === 7'b0,
           "outputs in reset",
           128'({busy, done, wrValid, overflow, ccLess, ccEqual, ccGreater}), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    report("R9", {busy, done, wrValid, overflow, ccLess, ccEqual, ccGreater} === 7'b0,
           "outputs after reset",
           128'({busy, done, wrValid, overflow, ccLess, ccEqual, ccGreater}), 128'(0));

    runOp(64'd0, 16'h0100, 8'd5, 1'b0);
    runOp(64'd12345, 16'h0200, 8'd8, 1'b0);
    runOp(-64'sd12345, 16'h0300, 8'd3, 1'b0);
    runOp(64'd9, 16'h0010, 8'd1, 1'b0);
    runOp(64'd10, 16'h0010, 8'd1, 1'b0);
    runOp(64'h7FFF_FFFF_FFFF_FFFF, 16'h0400, 8'd19, 1'b0);
    runOp(64'h8000_0000_0000_0000, 16'h0500, 8'd19, 1'b0);
    runOp(64'h8000_0000_0000_0000, 16'h0500, 8'd18, 1'b0);
    runOp(64'd0, 16'h0600, 8'd0, 1'b0);
    runOp(64'd7, 16'h0600, 8'd0, 1'b0);
    runOp(-64'sd1, 16'hFFFE, 8'd4, 1'b0);
    readyRandom = 1'b1;
    runOp(64'd987654321, 16'h0700, 8'd12, 1'b1);
    for (int n = 0; n < 30; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (n % 3 == 0) v = 64'($urandom % 100000);
      if (n % 5 == 1) v = -v;
      runOp(v, 16'($urandom), 8'($urandom % 23), 1'b0);
    end
    report("R7", holdViolations == 0, "write held while stalled",
           128'(holdViolations), 128'(0));
    finishRun();
  end
endmodule